// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block decides, for the instruction sitting in the execute stage of a five-stage in-order pipeline, where each of its two source operands should come from. It compares the two source register numbers of the EX instruction against the destination registers of the two older instructions still in flight, in the memory and write-back stages. For each operand it emits a select code. The code picks one of three values: the operand read from the register file in decode, the memory-stage result, or the write-back-stage result. The datapath multiplexers that these codes steer live outside the block.

The unit also raises a stall request when the memory-stage instruction is a load whose destination matches a source of the EX instruction. The loaded data cannot be forwarded in time in that case. Pipeline control uses the request to hold the front of the pipe for a cycle. The logic is purely combinational and looks only at register numbers and producer control flags, never at the opcode of the EX instruction. As a result, instructions that do not use a field, such as a jump, still get selects for it. A store uses both of its fields: one as the address base and one as the store data. Both fields therefore take part in the stall decision.

Top module: `operand_forward_unit`

## Requirements
- R1: An operand whose register number matches no eligible producer gets select code 2'b00 (decode-stage value).
- R2: An operand whose register number equals the memory-stage rd gets select code 2'b01, provided the memory-stage write-enable flag is set and that rd is nonzero.
- R3: An operand that matches an eligible write-back producer and no eligible memory-stage producer gets select code 2'b10. A write-back producer is eligible when its write-enable flag is set and its rd is nonzero.
- R4: When both the memory-stage and write-back-stage producers are eligible and match the same operand, the select is 2'b01, because the younger result wins.
- R5: A producer with rd equal to register 0 never causes forwarding or a stall, whatever its flags.
- R6: A producer whose write-enable flag is clear never causes forwarding or a stall. This holds even when its load flag is set.
- R7: The two operand selects are decided independently from their own register numbers. The same rule applies to both, with no dependence on whether the EX instruction reads that field.
- R8: The stall output is 1 exactly when the memory-stage producer has its load flag and write-enable flag set, a nonzero rd, and an rd equal to either EX source register.
- R9: When the memory-stage load's rd matches neither EX source register, the stall output is 0. This covers a store in EX whose base and data registers both differ from the load's rd.
- R10: Select code 2'b11 is never produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_src_a_i | input | 5 | First source register number of the EX instruction |
| ex_src_b_i | input | 5 | Second source register number of the EX instruction |
| mem_rd_i | input | 5 | Destination register of the memory-stage instruction |
| mem_wr_en_i | input | 1 | Memory-stage instruction writes the register file |
| mem_is_load_i | input | 1 | Memory-stage result comes from data memory |
| wb_rd_i | input | 5 | Destination register of the write-back-stage instruction |
| wb_wr_en_i | input | 1 | Write-back-stage instruction writes the register file |
| src_a_sel_o | output | 2 | Source choice for the first operand (00 decode, 01 MEM, 10 WB) |
| src_b_sel_o | output | 2 | Source choice for the second operand (00 decode, 01 MEM, 10 WB) |
| load_stall_o | output | 1 | Stall request for a load-use dependency on the MEM instruction |

## Verification
The hardest situations to reach are the ones where several conditions coincide. Examples are an operand matching both producers at once, a matching rd of zero, and a load in MEM whose rd hits only one of the two fields. With uniformly random 5-bit register numbers these arise very rarely. The random stimulus therefore draws register numbers from a small pool of low values that includes register 0, so that collisions and zero destinations become common. Directed cases then pin down the store-in-EX no-stall case and the dual-match priority case explicitly.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  localparam int unsigned REG_AW = 5;

  typedef enum logic [1:0] {
    SRC_DECODE = 2'b00,
    SRC_MEM    = 2'b01,
    SRC_WB     = 2'b10
  } src_sel_e;

  typedef struct packed {
    logic [REG_AW-1:0] rd;
    logic              wr_en;
  } producer_t;

endpackage

// File: rtl/fwd_match.sv
module fwd_match
  import fwd_pkg::*;
#(
  parameter int unsigned AW = REG_AW
) (
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] rd_i,
  input  logic          wr_en_i,
  output logic          hit_o
);

  logic rd_nonzero;
  logic rd_equal;

  always_comb begin
    rd_nonzero = |rd_i;
    rd_equal   = (rd_i == src_i);
    hit_o      = wr_en_i && rd_nonzero && rd_equal;
  end

endmodule

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
  import fwd_pkg::*;
#(
  parameter int unsigned AW = REG_AW
) (
  input  logic [AW-1:0] src_i,
  input  producer_t     mem_i,
  input  producer_t     wb_i,
  output src_sel_e      sel_o,
  output logic          mem_hit_o
);

  logic mem_hit;
  logic wb_hit;

  fwd_match #(.AW(AW)) u_mem_match (
    .src_i   (src_i),
    .rd_i    (mem_i.rd),
    .wr_en_i (mem_i.wr_en),
    .hit_o   (mem_hit)
  );

  fwd_match #(.AW(AW)) u_wb_match (
    .src_i   (src_i),
    .rd_i    (wb_i.rd),
    .wr_en_i (wb_i.wr_en),
    .hit_o   (wb_hit)
  );

  // younger producer has priority
  always_comb begin
    sel_o = SRC_DECODE;
    if (mem_hit) begin
      sel_o = SRC_MEM;
    end else if (wb_hit) begin
      sel_o = SRC_WB;
    end
    mem_hit_o = mem_hit;
  end

endmodule

// File: rtl/fwd_load_guard.sv
module fwd_load_guard #(
  parameter int unsigned NSRC = 2
) (
  input  logic [NSRC-1:0] mem_hit_i,
  input  logic            mem_is_load_i,
  output logic            stall_o
);

  always_comb begin
    stall_o = mem_is_load_i && (|mem_hit_i);
  end

endmodule

// File: rtl/operand_forward_unit.sv
module operand_forward_unit
  import fwd_pkg::*;
#(
  parameter int unsigned AW = REG_AW
) (
  input  logic [AW-1:0] ex_src_a_i,
  input  logic [AW-1:0] ex_src_b_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic          mem_wr_en_i,
  input  logic          mem_is_load_i,
  input  logic [AW-1:0] wb_rd_i,
  input  logic          wb_wr_en_i,
  output logic [1:0]    src_a_sel_o,
  output logic [1:0]    src_b_sel_o,
  output logic          load_stall_o
);

  localparam int unsigned NSRC = 2;

  producer_t         mem_prod;
  producer_t         wb_prod;
  logic [AW-1:0]     src_vec [NSRC];
  src_sel_e          sel_vec [NSRC];
  logic [NSRC-1:0]   mem_hit_vec;

  always_comb begin
    mem_prod.rd    = mem_rd_i;
    mem_prod.wr_en = mem_wr_en_i;
    wb_prod.rd     = wb_rd_i;
    wb_prod.wr_en  = wb_wr_en_i;
    src_vec[0]     = ex_src_a_i;
    src_vec[1]     = ex_src_b_i;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_operand
    fwd_operand_sel #(.AW(AW)) u_sel (
      .src_i     (src_vec[g]),
      .mem_i     (mem_prod),
      .wb_i      (wb_prod),
      .sel_o     (sel_vec[g]),
      .mem_hit_o (mem_hit_vec[g])
    );
  end

  fwd_load_guard #(.NSRC(NSRC)) u_load_guard (
    .mem_hit_i     (mem_hit_vec),
    .mem_is_load_i (mem_is_load_i),
    .stall_o       (load_stall_o)
  );

  always_comb begin
    src_a_sel_o = sel_vec[0];
    src_b_sel_o = sel_vec[1];
  end

endmodule

// File: rtl/operand_forward_unit_chk.sv
module operand_forward_unit_chk #(
  parameter int unsigned AW = 5
) (
  input logic [AW-1:0] ex_src_a_i,
  input logic [AW-1:0] ex_src_b_i,
  input logic [AW-1:0] mem_rd_i,
  input logic          mem_wr_en_i,
  input logic          mem_is_load_i,
  input logic [AW-1:0] wb_rd_i,
  input logic          wb_wr_en_i,
  input logic [1:0]    src_a_sel_o,
  input logic [1:0]    src_b_sel_o,
  input logic          load_stall_o
);

  always_comb begin
    AST_SEL_A_LEGAL: assert (src_a_sel_o != 2'b11);  // R10
    AST_SEL_B_LEGAL: assert (src_b_sel_o != 2'b11);  // R10
    AST_ZERO_MEM_NO_FWD: assert (!(mem_rd_i == '0 && (src_a_sel_o == 2'b01 || src_b_sel_o == 2'b01)));  // R5
    AST_ZERO_WB_NO_FWD: assert (!(wb_rd_i == '0 && (src_a_sel_o == 2'b10 || src_b_sel_o == 2'b10)));  // R5
    AST_NOWE_NO_STALL: assert (mem_wr_en_i || !load_stall_o);  // R6
    AST_STALL_NEEDS_LOAD: assert (mem_is_load_i || !load_stall_o);  // R8
    AST_STALL_NEEDS_MATCH: assert (!load_stall_o || src_a_sel_o == 2'b01 || src_b_sel_o == 2'b01);  // R9
    AST_MEM_PRIORITY: assert (!(mem_wr_en_i && mem_rd_i != '0 && mem_rd_i == ex_src_a_i) || src_a_sel_o == 2'b01);  // R4
    AST_WB_NEEDS_WE: assert (wb_wr_en_i || (src_a_sel_o != 2'b10 && src_b_sel_o != 2'b10));  // R6
  end

endmodule

bind operand_forward_unit operand_forward_unit_chk #(.AW(AW)) u_chk (
  .ex_src_a_i    (ex_src_a_i),
  .ex_src_b_i    (ex_src_b_i),
  .mem_rd_i      (mem_rd_i),
  .mem_wr_en_i   (mem_wr_en_i),
  .mem_is_load_i (mem_is_load_i),
  .wb_rd_i       (wb_rd_i),
  .wb_wr_en_i    (wb_wr_en_i),
  .src_a_sel_o   (src_a_sel_o),
  .src_b_sel_o   (src_b_sel_o),
  .load_stall_o  (load_stall_o)
);

// File: tb/operand_forward_unit_test.sv
`timescale 1ns/1ps
module operand_forward_unit_test;

  logic       clk;
  logic       rst_n;
  logic [4:0] src_a, src_b, mrd, wrd;
  logic       mwe, mld, wwe;
  logic [1:0] sel_a, sel_b;
  logic       stall;
  int         n_chk;
  int         n_fail;
  bit         done;

  operand_forward_unit uut (
    .ex_src_a_i    (src_a),
    .ex_src_b_i    (src_b),
    .mem_rd_i      (mrd),
    .mem_wr_en_i   (mwe),
    .mem_is_load_i (mld),
    .wb_rd_i       (wrd),
    .wb_wr_en_i    (wwe),
    .src_a_sel_o   (sel_a),
    .src_b_sel_o   (sel_b),
    .load_stall_o  (stall)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [1:0] exp_sel(input logic [4:0] s, input logic [4:0] md,
                                         input logic me, input logic [4:0] wd, input logic we);
    if (me && md != 5'd0 && md == s) return 2'b01;
    if (we && wd != 5'd0 && wd == s) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic exp_stall(input logic [4:0] a, input logic [4:0] b,
                                     input logic [4:0] md, input logic me, input logic ml);
    return me && ml && md != 5'd0 && (md == a || md == b);
  endfunction

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic apply(input logic [4:0] a, input logic [4:0] b, input logic [4:0] md,
                       input logic me, input logic ml, input logic [4:0] wd, input logic we);
    @(posedge clk);
    src_a = a; src_b = b; mrd = md; mwe = me; mld = ml; wrd = wd; wwe = we;
    @(negedge clk);
  endtask

  function automatic string tag_for(input logic [4:0] s, input logic [4:0] md, input logic me,
                                    input logic [4:0] wd, input logic we);
    logic mh, wh;
    mh = me && md != 5'd0 && md == s;
    wh = we && wd != 5'd0 && wd == s;
    if (mh && wh) return "R4 dual";
    if (mh) return "R2 mem";
    if (wh) return "R3 wb";
    if ((md == s && md == 5'd0) || (wd == s && wd == 5'd0)) return "R5 zero";
    if ((md == s && !me) || (wd == s && !we)) return "R6 nowe";
    return "R1 none";
  endfunction

  task automatic full_check(input string base);
    chk({base, " opA"}, sel_a, exp_sel(src_a, mrd, mwe, wrd, wwe));
    chk({base, " opB R7"}, sel_b, exp_sel(src_b, mrd, mwe, wrd, wwe));
    chk({base, " stall R8"}, {1'b0, stall}, {1'b0, exp_stall(src_a, src_b, mrd, mwe, mld)});
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    src_a = '0; src_b = '0; mrd = '0; wrd = '0; mwe = 1'b0; mld = 1'b0; wwe = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // idle inputs: decode selects, no stall
    chk("R1 idle opA", sel_a, 2'b00);
    chk("R1 idle opB", sel_b, 2'b00);
    chk("R9 idle stall", {1'b0, stall}, 2'b00);

    // MEM match on A only
    apply(5'd4, 5'd5, 5'd4, 1'b1, 1'b0, 5'd9, 1'b1);
    chk("R2 mem opA", sel_a, 2'b01);
    chk("R1 opB", sel_b, 2'b00);
    // WB match on B
    apply(5'd4, 5'd5, 5'd6, 1'b1, 1'b0, 5'd5, 1'b1);
    chk("R3 wb opB", sel_b, 2'b10);
    chk("R1 opA", sel_a, 2'b00);
    // dual match, MEM wins
    apply(5'd7, 5'd7, 5'd7, 1'b1, 1'b0, 5'd7, 1'b1);
    chk("R4 dual opA", sel_a, 2'b01);
    chk("R4 dual opB", sel_b, 2'b01);
    // rd zero on both producers
    apply(5'd0, 5'd0, 5'd0, 1'b1, 1'b1, 5'd0, 1'b1);
    chk("R5 zero opA", sel_a, 2'b00);
    chk("R5 zero stall", {1'b0, stall}, 2'b00);
    // write enable clear, load flag set
    apply(5'd3, 5'd8, 5'd3, 1'b0, 1'b1, 5'd8, 1'b0);
    chk("R6 nowe opA", sel_a, 2'b00);
    chk("R6 nowe opB", sel_b, 2'b00);
    chk("R6 nowe stall", {1'b0, stall}, 2'b00);
    // load hit on second field only
    apply(5'd2, 5'd11, 5'd11, 1'b1, 1'b1, 5'd0, 1'b0);
    chk("R8 load stall", {1'b0, stall}, 2'b01);
    // store in EX (base 2, data 5) behind load to r1: no stall
    apply(5'd2, 5'd5, 5'd1, 1'b1, 1'b1, 5'd5, 1'b1);
    chk("R9 store stall", {1'b0, stall}, 2'b00);
    chk("R3 store data", sel_b, 2'b10);

    void'($urandom(32'd20240611));
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] a, b, md, wd;
      a  = 5'($urandom % 4);
      b  = 5'($urandom % 4);
      md = 5'($urandom % 4);
      wd = 5'($urandom % 4);
      apply(a, b, md, 1'($urandom), 1'($urandom), wd, 1'($urandom));
      full_check(tag_for(src_a, mrd, mwe, wrd, wwe));
      chk("R10 legal", {1'b0, (sel_a == 2'b11) | (sel_b == 2'b11)}, 2'b00);
    end
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule